// File: doc/BRIEF.md
# DRAM Slot Arbiter with CPU Wait Generation

This block shares one DRAM between an 8-bit CPU and a video fetch engine. It splits every 1 µs frame into a fixed CPU slot and a fixed video slot. It runs from a clock at twice the 16 MHz memory rate, so a frame is 32 phases and column strobes can move on either edge of the 16 MHz clock. A free-running phase counter sets the whole schedule. The CPU cannot move a slot boundary. It can only hold its column strobe back and pick the write-enable level.

In the CPU slot the block always opens a row. It strobes a column only for a real memory read or write. For I/O and idle cycles the column strobe stays high, so the DRAM never drives the bus against I/O data. In the video slot the block opens one row and reads two adjacent bytes in page mode. The lowest byte-address bit comes from the byte index. The CPU wait line is released only in the middle of the CPU slot, which limits the CPU to one DRAM access per frame. The block also gives one-cycle strobes to latch the two video bytes and the CPU read data. All outputs come straight from flops.

Top module: `dram_slot_arbiter`

## Requirements
- R1: Phases run 0 to 31 and wrap. Reset sets the phase to 0. The clock edge that starts phase 0 samples the CPU request and CPU address for the frame. The clock edge that starts phase 12 samples the video enable and video word address.
- R2: `wait_n_o` is high in phases 4 to 11 and low in all other phases (0 to 3 and 12 to 31).
- R3: `ras_n_o` is low in phases 2 to 9 of every frame, whatever the CPU request is (none, read, write or I/O).
- R4: The CPU request code is 0 for none, 1 for memory read, 2 for memory write and 3 for I/O. In the CPU slot, `cas_n_o` is low in phases 6 to 9 only for codes 1 and 2. For codes 0 and 3 it stays high for the whole CPU slot.
- R5: `we_n_o` is low in phases 6 to 9 only when the request code is 2. It is high in every other case.
- R6: When the video slot is enabled, `ras_n_o` is low in phases 14 to 29 and `cas_n_o` is low in phases 18 to 21 (byte 0) and 24 to 27 (byte 1). The DRAM byte address is the video word address with bit 0 appended: 0 for byte 0, 1 for byte 1.
- R7: When the video slot is disabled, `ras_n_o` and `cas_n_o` stay high in phases 12 to 31 and no video latch strobe fires. `wait_n_o` follows R2 unchanged.
- R8: For a byte address A, the row is A's upper half and the column is A's lower half. `dram_addr_o` carries the CPU row in phases 0 to 3, the CPU column in 4 to 11, the video row in 12 to 15, the byte-0 column in 16 to 21 and the byte-1 column in 22 to 31. It does not change while `cas_n_o` is low.
- R9: `vid_latch_o[0]` pulses in phase 21 and `vid_latch_o[1]` pulses in phase 27, only when video is enabled. `cpu_rd_valid_o` pulses in phase 9, only for request code 1. Each pulse lasts one cycle.
- R10: Each frame has 1 + E falls of `ras_n_o` and M + 2E falls of `cas_n_o`. E is 1 when video is enabled and 0 otherwise. M is 1 for a CPU memory read or write and 0 otherwise.
- R11: During reset, `ras_n_o`, `cas_n_o` and `we_n_o` are high, `wait_n_o` is low, and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock, two phases per 16 MHz memory cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| cpu_req_i | input | 2 | CPU request code: 0 none, 1 read, 2 write, 3 I/O |
| cpu_addr_i | input | ADDR_W | CPU byte address |
| vid_addr_i | input | ADDR_W-1 | Video word address (byte pair) |
| vid_en_i | input | 1 | Enables the video slot's DRAM accesses |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | DRAM write enable, active low |
| dram_addr_o | output | ADDR_W/2 | Multiplexed row/column address |
| wait_n_o | output | 1 | CPU wait line, active low |
| vid_latch_o | output | 2 | Per-byte video data latch strobes |
| cpu_rd_valid_o | output | 1 | CPU read data valid strobe |

## Verification
Every output is a flop loaded from the decode of the next phase. So the value for phase p appears right after the edge that moves the counter to p, and it holds for one cycle. The bench keeps its own phase count from reset release. It also copies the CPU and video inputs at the same two sampling edges as the block. It compares every strobe, the address and the pulses at the falling clock edge in each phase, so each result is read one half-cycle after it is due. DRAM read data is taken at the sampled fall of the column strobe and checked at the latch or valid pulse three phases later. The per-frame strobe counts are checked in phase 31.

// File: rtl/dram_slot_pkg.sv
package dram_slot_pkg;

   localparam int PH_W = 5;
   typedef logic [PH_W-1:0] phase_t;

   typedef enum logic [1:0] {
      REQ_NONE = 2'd0,
      REQ_RD   = 2'd1,
      REQ_WR   = 2'd2,
      REQ_IO   = 2'd3
   } cpu_req_e;

   // CPU slot: phases 0..11
   localparam phase_t CPU_RAS_LO = 5'd2;
   localparam phase_t CPU_RAS_HI = 5'd9;
   localparam phase_t CPU_COL_AT = 5'd4;
   localparam phase_t CPU_CAS_LO = 5'd6;
   localparam phase_t CPU_CAS_HI = 5'd9;
   localparam phase_t CPU_REL_LO = 5'd4;
   localparam phase_t CPU_REL_HI = 5'd11;

   // video slot: phases 12..31
   localparam phase_t VID_START  = 5'd12;
   localparam phase_t VID_RAS_LO = 5'd14;
   localparam phase_t VID_RAS_HI = 5'd29;
   localparam int     VID_BYTES  = 2;
   localparam int     VID_COL0   = 16;
   localparam int     VID_CAS0   = 18;
   localparam int     VID_STEP   = 6;
   localparam int     VID_CASLEN = 4;

   typedef struct packed {
      logic                 ras;
      logic                 cas;
      logic                 we;
      logic                 wait_rel;
      logic [VID_BYTES-1:0] vlat;
      logic                 rd_valid;
   } strobe_t;

   function automatic logic in_win(input phase_t p, input phase_t lo, input phase_t hi);
      return (p >= lo) && (p <= hi);
   endfunction

endpackage

// File: rtl/slot_phase_ctr.sv
module slot_phase_ctr
   import dram_slot_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_i,
   output phase_t phase_q,
   output phase_t phase_nx
);

   assign phase_nx = phase_q + phase_t'(1);

   always_ff @(posedge clk_i) begin
      if (rst_i) phase_q <= '0;
      else       phase_q <= phase_nx;
   end

endmodule

// File: rtl/slot_strobe_dec.sv
module slot_strobe_dec
   import dram_slot_pkg::*;
(
   input  phase_t   ph_i,
   input  cpu_req_e req_i,
   input  logic     ven_i,
   output strobe_t  st_o
);

   logic                 mem_acc;
   logic [VID_BYTES-1:0] vcas;
   logic [VID_BYTES-1:0] vlat;

   assign mem_acc = (req_i == REQ_RD) || (req_i == REQ_WR);

   for (genvar b = 0; b < VID_BYTES; b++) begin : g_vbyte
      localparam int     LO_I = VID_CAS0 + b * VID_STEP;
      localparam phase_t LO   = phase_t'(LO_I);
      localparam phase_t HI   = phase_t'(LO_I + VID_CASLEN - 1);
      assign vcas[b] = ven_i && in_win(ph_i, LO, HI);
      assign vlat[b] = ven_i && (ph_i == HI);
   end

   always_comb begin
      st_o          = '0;
      st_o.ras      = in_win(ph_i, CPU_RAS_LO, CPU_RAS_HI) ||
                      (ven_i && in_win(ph_i, VID_RAS_LO, VID_RAS_HI));
      st_o.cas      = (mem_acc && in_win(ph_i, CPU_CAS_LO, CPU_CAS_HI)) || (|vcas);
      st_o.we       = (req_i == REQ_WR) && in_win(ph_i, CPU_CAS_LO, CPU_CAS_HI);
      st_o.wait_rel = in_win(ph_i, CPU_REL_LO, CPU_REL_HI);
      st_o.vlat     = vlat;
      st_o.rd_valid = (req_i == REQ_RD) && (ph_i == CPU_CAS_HI);
   end

endmodule

// File: rtl/slot_addr_mux.sv
module slot_addr_mux
   import dram_slot_pkg::*;
#(
   parameter int ADDR_W = 16,
   localparam int HALF_W = ADDR_W / 2
) (
   input  phase_t              ph_i,
   input  logic [ADDR_W-1:0]   cpu_addr_i,
   input  logic [ADDR_W-2:0]   vid_addr_i,
   output logic [HALF_W-1:0]   addr_o
);

   logic [HALF_W-1:0] vcol [VID_BYTES];
   logic [HALF_W-1:0] vrow;

   assign vrow = vid_addr_i[ADDR_W-2:HALF_W-1];

   for (genvar b = 0; b < VID_BYTES; b++) begin : g_vcol
      assign vcol[b] = {vid_addr_i[HALF_W-2:0], 1'(b)};
   end

   localparam phase_t COL1_AT = phase_t'(VID_COL0 + VID_STEP);
   localparam phase_t COL0_AT = phase_t'(VID_COL0);

   always_comb begin
      if (ph_i < CPU_COL_AT)      addr_o = cpu_addr_i[ADDR_W-1:HALF_W];
      else if (ph_i < VID_START)  addr_o = cpu_addr_i[HALF_W-1:0];
      else if (ph_i < COL0_AT)    addr_o = vrow;
      else if (ph_i < COL1_AT)    addr_o = vcol[0];
      else                        addr_o = vcol[1];
   end

endmodule

// File: rtl/dram_slot_arbiter.sv
module dram_slot_arbiter
   import dram_slot_pkg::*;
#(
   parameter int ADDR_W = 16,
   localparam int HALF_W = ADDR_W / 2,
   localparam int VADDR_W = ADDR_W - 1
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic [1:0]           cpu_req_i,
   input  logic [ADDR_W-1:0]    cpu_addr_i,
   input  logic [VADDR_W-1:0]   vid_addr_i,
   input  logic                 vid_en_i,
   output logic                 ras_n_o,
   output logic                 cas_n_o,
   output logic                 we_n_o,
   output logic [HALF_W-1:0]    dram_addr_o,
   output logic                 wait_n_o,
   output logic [VID_BYTES-1:0] vid_latch_o,
   output logic                 cpu_rd_valid_o
);

   if (ADDR_W < 4 || (ADDR_W % 2) != 0) begin : g_bad_addr_w
      $error("dram_slot_arbiter: ADDR_W must be even and at least 4");
   end

   phase_t              ph_q, ph_nx;
   cpu_req_e            req_q, req_eff;
   logic [ADDR_W-1:0]   caddr_q, caddr_eff;
   logic                ven_q, ven_eff;
   logic [VADDR_W-1:0]  vaddr_q, vaddr_eff;
   strobe_t             st;
   logic [HALF_W-1:0]   addr_nx;
   logic                frame_start, vid_start;

   slot_phase_ctr u_ctr (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .phase_q (ph_q),
      .phase_nx(ph_nx)
   );

   assign frame_start = (ph_nx == '0);
   assign vid_start   = (ph_nx == VID_START);
   assign req_eff     = frame_start ? cpu_req_e'(cpu_req_i) : req_q;
   assign caddr_eff   = frame_start ? cpu_addr_i : caddr_q;
   assign ven_eff     = vid_start ? vid_en_i : ven_q;
   assign vaddr_eff   = vid_start ? vid_addr_i : vaddr_q;

   slot_strobe_dec u_dec (
      .ph_i (ph_nx),
      .req_i(req_eff),
      .ven_i(ven_eff),
      .st_o (st)
   );

   slot_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
      .ph_i      (ph_nx),
      .cpu_addr_i(caddr_eff),
      .vid_addr_i(vaddr_eff),
      .addr_o    (addr_nx)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         req_q          <= REQ_NONE;
         caddr_q        <= '0;
         ven_q          <= 1'b0;
         vaddr_q        <= '0;
         ras_n_o        <= 1'b1;
         cas_n_o        <= 1'b1;
         we_n_o         <= 1'b1;
         wait_n_o       <= 1'b0;
         vid_latch_o    <= '0;
         cpu_rd_valid_o <= 1'b0;
         dram_addr_o    <= '0;
      end else begin
         req_q          <= req_eff;
         caddr_q        <= caddr_eff;
         ven_q          <= ven_eff;
         vaddr_q        <= vaddr_eff;
         ras_n_o        <= ~st.ras;
         cas_n_o        <= ~st.cas;
         we_n_o         <= ~st.we;
         wait_n_o       <= st.wait_rel;
         vid_latch_o    <= st.vlat;
         cpu_rd_valid_o <= st.rd_valid;
         dram_addr_o    <= addr_nx;
      end
   end

   // R4 / R6: a column strobe only inside an open row
   a_r4_cas_inside_ras: assert property (@(posedge clk_i) disable iff (rst_i)
      !cas_n_o |-> !ras_n_o);

   // R5: write enable only while a column strobe is low
   a_r5_we_with_cas: assert property (@(posedge clk_i) disable iff (rst_i)
      !we_n_o |-> !cas_n_o);

   // R8: column address held while its strobe is low
   a_r8_col_held: assert property (@(posedge clk_i) disable iff (rst_i)
      (!cas_n_o && $past(!cas_n_o)) |-> $stable(dram_addr_o));

   // R9: latch strobes fall inside a read column strobe
   a_r9_latch_in_read: assert property (@(posedge clk_i) disable iff (rst_i)
      ((|vid_latch_o) || cpu_rd_valid_o) |-> (!cas_n_o && we_n_o));

   // R9: read-valid lasts a single cycle
   a_r9_rdv_single: assert property (@(posedge clk_i) disable iff (rst_i)
      cpu_rd_valid_o |=> !cpu_rd_valid_o);

   // R2: CPU held off for the whole video slot
   a_r2_wait_in_video: assert property (@(posedge clk_i) disable iff (rst_i)
      (ph_q >= VID_START) |-> !wait_n_o);

   // R3: CPU row open mid-slot whatever the request
   a_r3_cpu_row_open: assert property (@(posedge clk_i) disable iff (rst_i)
      (ph_q == CPU_CAS_LO) |-> !ras_n_o);

   // R1: at most one latch strobe at a time
   a_r1_one_latch: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0({vid_latch_o, cpu_rd_valid_o}));

endmodule

// File: tb/tb_dram_slot_arbiter.sv
module tb_dram_slot_arbiter;

   localparam int AW = 10;
   localparam int HW = AW / 2;
   localparam int MEMSZ = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    cpu_req = 2'd0;
   logic [AW-1:0] cpu_addr = '0;
   logic [AW-2:0] vid_addr = '0;
   logic          vid_en = 1'b0;
   logic          ras_n, cas_n, we_n, wait_n, rdv;
   logic [HW-1:0] dram_addr;
   logic [1:0]    vlat;

   dram_slot_arbiter #(.ADDR_W(AW)) dut (
      .clk_i(clk), .rst_i(rst), .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr),
      .vid_addr_i(vid_addr), .vid_en_i(vid_en), .ras_n_o(ras_n), .cas_n_o(cas_n),
      .we_n_o(we_n), .dram_addr_o(dram_addr), .wait_n_o(wait_n),
      .vid_latch_o(vlat), .cpu_rd_valid_o(rdv)
   );

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit chk_on = 1'b0;

   // bench model of phase and sampled frame inputs (R1)
   int            ph;
   logic [1:0]    cq_req;
   logic [AW-1:0] cq_addr;
   logic          vq_en;
   logic [AW-2:0] vq_addr;

   always @(posedge clk) begin
      if (rst) begin
         ph <= 0; cq_req <= 2'd0; cq_addr <= '0; vq_en <= 1'b0; vq_addr <= '0;
      end else begin
         ph <= (ph == 31) ? 0 : ph + 1;
         if (ph == 31) begin cq_req <= cpu_req; cq_addr <= cpu_addr; end
         if (ph == 11) begin vq_en <= vid_en; vq_addr <= vid_addr; end
      end
   end

   // behavioural DRAM and shadow
   logic [7:0]    dram    [MEMSZ];
   logic [7:0]    exp_mem [MEMSZ];
   logic [7:0]    wdata = 8'h00;
   logic [7:0]    rdata = 8'h00;
   logic [HW-1:0] row_q = '0;
   logic          prev_ras = 1'b1, prev_cas = 1'b1;
   int            ras_falls = 0, cas_falls = 0;

   initial begin
      for (int i = 0; i < MEMSZ; i++) begin
         dram[i]    = 8'((i * 7 + 3) & 255);
         exp_mem[i] = 8'((i * 7 + 3) & 255);
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (phase %0d)", tag, act, exp, ph);
      end
   endtask

   function automatic bit inw(input int p, input int lo, input int hi);
      return (p >= lo) && (p <= hi);
   endfunction

   always @(negedge clk) begin
      if (chk_on) begin
         logic [AW-1:0] vb0, vb1, a;
         logic [HW-1:0] ea;
         bit mem, e_ras, e_cas, e_we;
         // DRAM model
         if (prev_ras && !ras_n) begin row_q = dram_addr; ras_falls++; end
         if (prev_cas && !cas_n) begin
            cas_falls++;
            a = {row_q, dram_addr};
            if (!we_n) dram[a] = wdata;
            else       rdata   = dram[a];
         end
         prev_ras = ras_n;
         prev_cas = cas_n;

         mem   = (cq_req == 2'd1) || (cq_req == 2'd2);
         e_ras = inw(ph, 2, 9) || (vq_en && inw(ph, 14, 29));
         e_cas = (mem && inw(ph, 6, 9)) || (vq_en && (inw(ph, 18, 21) || inw(ph, 24, 27)));
         e_we  = (cq_req == 2'd2) && inw(ph, 6, 9);
         vb0   = {vq_addr, 1'b0};
         vb1   = {vq_addr, 1'b1};
         if (ph < 4)       ea = cq_addr[AW-1:HW];
         else if (ph < 12) ea = cq_addr[HW-1:0];
         else if (ph < 16) ea = vb0[AW-1:HW];
         else if (ph < 22) ea = vb0[HW-1:0];
         else              ea = vb1[HW-1:0];

         check(ph < 12 ? "R3 ras_n cpu slot" : (vq_en ? "R6 ras_n video" : "R7 ras_n video off"),
               32'(ras_n), 32'(!e_ras));
         check(ph < 12 ? "R4 cas_n cpu slot" : (vq_en ? "R6 cas_n video" : "R7 cas_n video off"),
               32'(cas_n), 32'(!e_cas));
         check("R5 we_n", 32'(we_n), 32'(!e_we));
         check("R2 wait_n", 32'(wait_n), 32'(inw(ph, 4, 11)));
         check("R8 dram_addr", 32'(dram_addr), 32'(ea));
         check("R9 video latch strobes", 32'(vlat), 32'({vq_en && ph == 27, vq_en && ph == 21}));
         check("R9 cpu read valid", 32'(rdv), 32'(cq_req == 2'd1 && ph == 9));

         if (rdv)     check("R4 cpu read data", 32'(rdata), 32'(exp_mem[cq_addr]));
         if (vlat[0]) check("R6 video byte0 data", 32'(rdata), 32'(exp_mem[vb0]));
         if (vlat[1]) check("R6 video byte1 data", 32'(rdata), 32'(exp_mem[vb1]));

         if (ph == 31) begin
            check("R10 R1 ras falls per frame", 32'(ras_falls), 32'(1 + int'(vq_en)));
            check("R10 R1 cas falls per frame", 32'(cas_falls), 32'(int'(mem) + 2 * int'(vq_en)));
            ras_falls = 0;
            cas_falls = 0;
         end
      end
   end

   task automatic issue(input logic [1:0] rq, input logic [AW-1:0] a, input logic ve,
                        input logic [AW-2:0] va, input logic [7:0] wd);
      @(negedge clk);
      while (ph != 31) @(negedge clk);
      cpu_req  = rq;
      cpu_addr = a;
      vid_en   = ve;
      vid_addr = va;
      wdata    = wd;
      if (rq == 2'd2) exp_mem[a] = wd;
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected run completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11 reset state
      check("R11 reset ras_n", 32'(ras_n), 32'd1);
      check("R11 reset cas_n", 32'(cas_n), 32'd1);
      check("R11 reset we_n", 32'(we_n), 32'd1);
      check("R11 reset wait_n", 32'(wait_n), 32'd0);
      check("R11 reset pulses", 32'({vlat, rdv}), 32'd0);
      rst    = 1'b0;
      chk_on = 1'b1;

      issue(2'd2, 10'h3FF, 1'b1, 9'h1FF, 8'hA5);
      issue(2'd1, 10'h3FF, 1'b0, 9'h000, 8'h00);
      issue(2'd3, 10'h155, 1'b1, 9'h0AA, 8'h00);
      issue(2'd0, 10'h000, 1'b1, 9'h155, 8'h00);
      issue(2'd2, 10'h000, 1'b0, 9'h000, 8'h3C);
      issue(2'd1, 10'h000, 1'b1, 9'h000, 8'h00);
      for (int i = 0; i < 32; i++) begin
         issue(2'(i % 4), 10'((i * 37 + 5) & 1023), 1'((i >> 2) & 1),
               9'((i * 53 + 7) & 511), 8'((i * 29 + 17) & 255));
      end
      for (int i = 0; i < 8; i++) begin
         issue(2'd1, 10'((i * 37 + 5) & 1023), 1'b1, 9'((i * 37 + 5) >> 1), 8'h00);
      end
      issue(2'd0, '0, 1'b0, '0, 8'h00);
      issue(2'd0, '0, 1'b0, '0, 8'h00);
      issue(2'd0, '0, 1'b0, '0, 8'h00);
      finish_run();
   end

endmodule